// File: doc/BRIEF.md
# Row-Programmable Mealy State Machine

This block is a finite state machine whose behaviour is loaded at run time rather than fixed at synthesis. Its hardware is a state register plus an array of transition rows. Each row stands for one arrow of the target state diagram. A row stores a source state, a set of input selectors, a small truth table over the inputs it selects, a destination state and an output pattern. In any cycle, a row fires when the current state equals its source state and its truth table returns 1 for the selected inputs. The firing row drives the output bus combinationally, which gives Mealy behaviour. On the next rising clock edge its destination state is loaded into the state register.

Parameters fix the input width, the output width and the state width. A ten-entry count sets how many rows of each observed-input width, from 0 to 9, are built. A row that observes no inputs gives an unconditional step. All row settings sit in one serial configuration chain. While configuration mode is raised, every row setting reads as zero, so no row fires. Software shifts a new image in one bit per clock, least significant bit first, and can capture the old image at the serial output. Dropping configuration mode puts the new image into effect at once.

Top module: `trow_fsm`

## Requirements
- R1: The output bus equals the output pattern of the firing row in the same cycle, with no clock edge in between. It changes with the inputs while the state is unchanged.
- R2: A row fires only when its source-state field equals the current state and its truth-table bit is 1. The table is indexed by the selected inputs, with selector 0 giving index bit 0. A selector value of j picks input bit j.
- R3: On a rising clock edge with a row firing, the state register takes that row's destination state.
- R4: The loaded image must make at most one row fire in any cycle. The outputs are defined only under that condition.
- R5: When no row fires, the output bus is all zeros and the state register keeps its value.
- R6: A row that observes no inputs fires whenever its source state matches and bit 0 of its table is 1.
- R7: While cfg_mode is 1, every row setting reads as zero: the outputs are zero and the state holds. The stored image is kept, and when cfg_mode returns to 0 the image acts again in the same cycle.
- R8: While cfg_mode and cfg_shift are both 1, each clock edge moves the chain one place toward bit 0, with cfg_din entering the top bit. cfg_dout always shows bit 0. After as many edges as the chain has bits, an image sent LSB first is in place, and the old image has appeared on cfg_dout in order from bit 0.
- R9: Image layout: rows are ordered by observed width, ascending, and then by index within each width. Each row takes its fields from its lowest bit upward: source state (state width), selectors (one field of ceil(log2(input width)) bits per observed input, selector 0 first), truth table (2^width bits), destination state, output pattern.
- R10: Driving rst_n low clears the state register and the whole chain to zero at once, without waiting for a clock edge.
- R11: While cfg_mode is 0, cfg_shift and cfg_din have no effect on the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsm_in | input | IN_W | Machine inputs |
| fsm_out | output | OUT_W | Machine outputs (Mealy) |
| cfg_mode | input | 1 | Configuration mode; masks all row settings |
| cfg_shift | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out (chain bit 0) |

## Verification
The assertions assume that the loaded image never lets two rows fire together, which is the condition in R4. They also assume that cfg_din and cfg_shift change only between clock edges. The bench loads one image whose rows leaving each state observe mutually exclusive input patterns. It drives only input vectors whose expected transition has been worked out by hand. It changes every input on the falling edge. Parts of the sequence deliberately make no row fire, so the hold-and-zero-output behaviour is exercised without breaking the exclusivity assumption.

// File: rtl/trow_fsm_pkg.sv
package trow_fsm_pkg;

    localparam int MAX_WIDTHS = 10;

    // Per-width row counts: element w gives the number of rows observing w inputs.
    typedef logic [MAX_WIDTHS-1:0][7:0] row_cnt_t;

    function automatic int sel_bits(input int in_w);
        return (in_w > 1) ? $clog2(in_w) : 1;
    endfunction

    function automatic int row_bits(input int w, input int in_w,
                                    input int st_w, input int out_w);
        return 2 * st_w + w * sel_bits(in_w) + (1 << w) + out_w;
    endfunction

    // Bit offset of row k among rows of width w, in the full chain.
    function automatic int row_base(input row_cnt_t cnt, input int w, input int k,
                                    input int in_w, input int st_w, input int out_w);
        int acc;
        acc = 0;
        for (int v = 0; v < MAX_WIDTHS; v++) begin
            if (v < w) acc += int'(cnt[v]) * row_bits(v, in_w, st_w, out_w);
        end
        if (w < MAX_WIDTHS) acc += k * row_bits(w, in_w, st_w, out_w);
        return acc;
    endfunction

    function automatic int row_index(input row_cnt_t cnt, input int w, input int k);
        int acc;
        acc = 0;
        for (int v = 0; v < MAX_WIDTHS; v++) begin
            if (v < w) acc += int'(cnt[v]);
        end
        return acc + k;
    endfunction

    function automatic int total_rows(input row_cnt_t cnt);
        return row_index(cnt, MAX_WIDTHS, 0);
    endfunction

    function automatic int total_bits(input row_cnt_t cnt, input int in_w,
                                      input int st_w, input int out_w);
        return row_base(cnt, MAX_WIDTHS, 0, in_w, st_w, out_w);
    endfunction

endpackage

// File: rtl/trow_fsm_row.sv
module trow_fsm_row
    import trow_fsm_pkg::*;
#(
    parameter int IN_W  = 4,
    parameter int OUT_W = 4,
    parameter int ST_W  = 3,
    parameter int WIDTH = 1
) (
    input  logic [row_bits(WIDTH, IN_W, ST_W, OUT_W)-1:0] cfg,
    input  logic [ST_W-1:0]                               cur_state,
    input  logic [IN_W-1:0]                               fsm_in,
    output logic                                          fire,
    output logic [ST_W-1:0]                               dest,
    output logic [OUT_W-1:0]                              pattern
);
    localparam int SELW   = sel_bits(IN_W);
    localparam int SEL_LO = ST_W;
    localparam int TBL_LO = SEL_LO + WIDTH * SELW;
    localparam int TBL_N  = 1 << WIDTH;
    localparam int DST_LO = TBL_LO + TBL_N;
    localparam int PAT_LO = DST_LO + ST_W;

    logic [ST_W-1:0]  src;
    logic [TBL_N-1:0] table_bits;
    logic             hit;

    assign src        = cfg[0 +: ST_W];
    assign table_bits = cfg[TBL_LO +: TBL_N];
    assign dest       = cfg[DST_LO +: ST_W];
    assign pattern    = cfg[PAT_LO +: OUT_W];

    generate
        if (WIDTH == 0) begin : g_uncond
            assign hit = table_bits[0];
        end else begin : g_cond
            logic [WIDTH-1:0] idx;
            for (genvar j = 0; j < WIDTH; j++) begin : g_sel
                logic [SELW-1:0] sel;
                assign sel    = cfg[SEL_LO + j*SELW +: SELW];
                assign idx[j] = (int'(sel) < IN_W) ? fsm_in[sel] : 1'b0;
            end
            assign hit = table_bits[idx];
        end
    endgenerate

    assign fire = hit && (src == cur_state);

endmodule

// File: rtl/trow_fsm_cfgchain.sv
module trow_fsm_cfgchain #(
    parameter int NBITS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode,
    input  logic             shift,
    input  logic             din,
    output logic [NBITS-1:0] image,
    output logic             dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            image <= '0;
        end else if (mode && shift) begin
            image <= {din, image[NBITS-1:1]};
        end
    end

    assign dout = image[0];

endmodule

// File: rtl/trow_fsm.sv
module trow_fsm
    import trow_fsm_pkg::*;
#(
    parameter int       IN_W          = 4,
    parameter int       OUT_W         = 4,
    parameter int       ST_W          = 3,
    parameter row_cnt_t ROWS_BY_WIDTH = {8'd0, 8'd0, 8'd0, 8'd0, 8'd0,
                                         8'd0, 8'd2, 8'd3, 8'd4, 8'd2}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  fsm_in,
    output logic [OUT_W-1:0] fsm_out,
    input  logic             cfg_mode,
    input  logic             cfg_shift,
    input  logic             cfg_din,
    output logic             cfg_dout
);
    localparam int NUM_ROWS = total_rows(ROWS_BY_WIDTH);
    localparam int CFG_N    = total_bits(ROWS_BY_WIDTH, IN_W, ST_W, OUT_W);

    logic [CFG_N-1:0]  image;
    logic [CFG_N-1:0]  image_eff;
    logic [ST_W-1:0]   state_q;
    logic [ST_W-1:0]   nxt_sel;
    logic [NUM_ROWS-1:0] row_act;
    logic [ST_W-1:0]   row_dst [NUM_ROWS];
    logic [OUT_W-1:0]  row_pat [NUM_ROWS];

    trow_fsm_cfgchain #(.NBITS(CFG_N)) chain_i (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (cfg_mode),
        .shift (cfg_shift),
        .din   (cfg_din),
        .image (image),
        .dout  (cfg_dout)
    );

    // Row settings are masked while a new image is being shifted in.
    assign image_eff = cfg_mode ? '0 : image;

    generate
        for (genvar w = 0; w < MAX_WIDTHS; w++) begin : g_width
            for (genvar k = 0; k < int'(ROWS_BY_WIDTH[w]); k++) begin : g_row
                localparam int BASE = row_base(ROWS_BY_WIDTH, w, k, IN_W, ST_W, OUT_W);
                localparam int RB   = row_bits(w, IN_W, ST_W, OUT_W);
                localparam int IDX  = row_index(ROWS_BY_WIDTH, w, k);
                trow_fsm_row #(
                    .IN_W(IN_W), .OUT_W(OUT_W), .ST_W(ST_W), .WIDTH(w)
                ) row_i (
                    .cfg       (image_eff[BASE +: RB]),
                    .cur_state (state_q),
                    .fsm_in    (fsm_in),
                    .fire      (row_act[IDX]),
                    .dest      (row_dst[IDX]),
                    .pattern   (row_pat[IDX])
                );
            end
        end
    endgenerate

    // Gated OR of all rows; with one firing row this selects it.
    always_comb begin
        nxt_sel = '0;
        fsm_out = '0;
        for (int r = 0; r < NUM_ROWS; r++) begin
            nxt_sel |= row_dst[r] & {ST_W{row_act[r]}};
            fsm_out |= row_pat[r] & {OUT_W{row_act[r]}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (|row_act) begin
            state_q <= nxt_sel;
        end
    end

endmodule

// File: rtl/trow_fsm_chk.sv
module trow_fsm_chk #(
    parameter int NR    = 4,
    parameter int ST_W  = 3,
    parameter int OUT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NR-1:0]    row_act,
    input logic [ST_W-1:0]  state_q,
    input logic [ST_W-1:0]  nxt_sel,
    input logic [OUT_W-1:0] fsm_out,
    input logic             cfg_mode,
    input logic             cfg_shift,
    input logic             cfg_dout
);
    p_single_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_act));

    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (row_act == '0) |-> (fsm_out == '0));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (row_act == '0) |=> (state_q == $past(state_q)));

    p_load_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_act != '0) |=> (state_q == $past(nxt_sel)));

    p_mode_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode |-> (row_act == '0 && fsm_out == '0));

    p_chain_still_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_mode && cfg_shift) |=> $stable(cfg_dout));

endmodule

bind trow_fsm trow_fsm_chk #(.NR(NUM_ROWS), .ST_W(ST_W), .OUT_W(OUT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_act   (row_act),
    .state_q   (state_q),
    .nxt_sel   (nxt_sel),
    .fsm_out   (fsm_out),
    .cfg_mode  (cfg_mode),
    .cfg_shift (cfg_shift),
    .cfg_dout  (cfg_dout)
);

// File: tb/trow_fsm_tb_top.sv
module trow_fsm_tb_top;
    localparam int TOT = 180;   // 2*11 + 4*14 + 3*18 + 2*24 for the default sizing

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] fsm_in = '0;
    logic [3:0] fsm_out;
    logic       cfg_mode = 1'b0;
    logic       cfg_shift = 1'b0;
    logic       cfg_din = 1'b0;
    logic       cfg_dout;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [TOT-1:0] img;

    always #4 clk = ~clk;

    trow_fsm dut_i (
        .clk(clk), .rst_n(rst_n), .fsm_in(fsm_in), .fsm_out(fsm_out),
        .cfg_mode(cfg_mode), .cfg_shift(cfg_shift), .cfg_din(cfg_din),
        .cfg_dout(cfg_dout)
    );

    // {inputs, expected outputs}; output = {1, destination} or 0 when idle
    localparam logic [7:0] VEC [21] = '{
        8'h0_0, 8'h1_9, 8'h0_0, 8'h2_A, 8'h0_8, 8'h1_9, 8'h2_A,
        8'h8_B, 8'h6_0, 8'hE_8, 8'h1_9, 8'h2_A, 8'h9_C, 8'h0_D,
        8'hF_8, 8'h1_9, 8'h2_A, 8'h8_B, 8'h4_C, 8'h0_D, 8'h0_8
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // R9 layout: src(3) | selectors(2 each) | table(2^w) | dest(3) | pattern(4)
    task automatic put_row(input int base, input int w, input int src,
                           input logic [5:0] sels, input logic [7:0] tbl, input int nx);
        int p;
        for (int i = 0; i < 3; i++) img[base + i] = src[i];
        p = base + 3;
        for (int i = 0; i < 2 * w; i++) img[p + i] = sels[i];
        p += 2 * w;
        for (int i = 0; i < (1 << w); i++) img[p + i] = tbl[i];
        p += (1 << w);
        for (int i = 0; i < 3; i++) img[p + i] = nx[i];
        p += 3;
        for (int i = 0; i < 3; i++) img[p + i] = nx[i];
        img[p + 3] = 1'b1;
    endtask

    task automatic build_image();
        img = '0;
        put_row(0,   0, 4, 6'd0,        8'h01,        5);  // R6 unconditional
        put_row(11,  0, 5, 6'd0,        8'h01,        0);
        put_row(22,  1, 0, 6'd0,        8'b10,        1);  // in0
        put_row(36,  1, 1, 6'd1,        8'b10,        2);  // in1
        put_row(50,  1, 2, 6'd3,        8'b01,        0);  // !in3
        put_row(78,  2, 2, 6'b0011,     8'b0010,      3);  // in3 & !in0
        put_row(96,  2, 2, 6'b0011,     8'b1000,      4);  // in3 & in0
        put_row(114, 2, 3, 6'b1001,     8'b0110,      4);  // in1 ^ in2
        put_row(132, 3, 3, 6'b111001,   8'b1001_0000, 0);  // in3 & (in1 == in2)
    endtask

    task automatic load_image();
        @(negedge clk);
        cfg_mode = 1'b1;
        cfg_shift = 1'b1;
        for (int i = 0; i < TOT; i++) begin
            cfg_din = img[i];
            @(negedge clk);
        end
        cfg_shift = 1'b0;
        cfg_din = 1'b0;
        cfg_mode = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int errs;
        build_image();
        // R10: held in reset, empty chain -> nothing fires
        fsm_in = 4'hF;
        #10;
        check("R10 reset output", {4'h0, fsm_out}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        fsm_in = 4'h0;

        load_image();

        // R1 R2 R3 R5 R6: table walk, one transition per cycle
        for (int v = 0; v < 21; v++) begin
            fsm_in = VEC[v][7:4];
            #1;
            check($sformatf("R1/R2/R3/R5/R6 vector %0d", v), {4'h0, fsm_out}, {4'h0, VEC[v][3:0]});
            @(negedge clk);
        end

        // R11: shifting with mode low leaves the chain alone (state 0)
        fsm_in = 4'h0;
        cfg_shift = 1'b1;
        cfg_din = 1'b1;
        repeat (5) @(negedge clk);
        cfg_shift = 1'b0;
        cfg_din = 1'b0;
        check("R11 serial out unchanged", {7'h0, cfg_dout}, {7'h0, img[0]});
        fsm_in = 4'h1;
        #1;
        check("R11 function kept", {4'h0, fsm_out}, 8'h09);
        @(negedge clk);   // state 1

        // R7: masked in config mode, state held, immediate return
        fsm_in = 4'h2;
        cfg_mode = 1'b1;
        #1;
        check("R7 masked output", {4'h0, fsm_out}, 8'h00);
        repeat (3) @(negedge clk);
        check("R7 still masked", {4'h0, fsm_out}, 8'h00);
        cfg_mode = 1'b0;
        #1;
        check("R7 restored, state held", {4'h0, fsm_out}, 8'h0A);
        @(negedge clk);   // state 2

        // R8: read old image back while shifting in zeros
        fsm_in = 4'h0;
        cfg_mode = 1'b1;
        cfg_shift = 1'b1;
        cfg_din = 1'b0;
        errs = 0;
        for (int i = 0; i < TOT; i++) begin
            if (cfg_dout !== img[i]) errs++;
            @(negedge clk);
        end
        cfg_shift = 1'b0;
        cfg_mode = 1'b0;
        check("R8 readback mismatches", errs[7:0], 8'h00);
        // R5: empty image, nothing fires
        fsm_in = 4'h8;
        #1;
        check("R5 empty image output", {4'h0, fsm_out}, 8'h00);

        // R10: asynchronous reset mid-run
        load_image();
        fsm_in = 4'h8;       // state 2 kept through the empty image
        #1;
        check("R8 reload takes effect", {4'h0, fsm_out}, 8'h0B);
        @(negedge clk);      // state 3
        #2;
        rst_n = 1'b0;
        #1;
        check("R10 async clear output", {4'h0, fsm_out}, 8'h00);
        check("R10 chain cleared", {7'h0, cfg_dout}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        load_image();
        fsm_in = 4'h2;
        #1;
        check("R10 state zero after reset", {4'h0, fsm_out}, 8'h00);
        fsm_in = 4'h1;
        #1;
        check("R10 state zero transition", {4'h0, fsm_out}, 8'h09);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule